// File: doc/BRIEF.md
# Boundary-Scan Test Pattern Engine

This block holds the test data path at the I/O boundary of a device: a boundary shift register with one cell per input pin and one per output pin, an update latch that can take over the output pins, and a one-bit bypass register. A test access port controller, which lies outside this block, drives it through a parallel instruction load strobe and through capture, shift, update and run-test strobes. The engine decodes the instruction and then chooses which data register sits between serial in and serial out. It also decides whether the output pins follow the functional core or the test logic.

Beyond plain observe-and-drive boundary testing, four self-test modes act on the update latch once per run-test strobe. Signature compression folds the input pins into an LFSR. Pseudorandom generation steps a maximal-length LFSR. Toggle inverts the outputs while it samples the inputs. Count increments the outputs. The decoder executes an instruction only when its opcode has even parity. Any other opcode falls back to bypass, and so does any even opcode that is not defined.

Top module: `bscan_pattern_engine`

## Requirements
- R1: After reset the engine is in bypass mode, and the outputs follow the core: pin_out equals func_out and pin_oe equals func_oe.
- R2: An opcode with an odd number of ones (for example 5'b00001) selects bypass mode. The core keeps control of the pins, and the one-bit bypass register sits between tdi and tdo.
- R3: SAMPLE (5'b00011) leaves the pins with the core. On capture, bits [W-1:0] of the boundary register take pin_in and bits [2W-1:W] take func_out. Shifting moves the register toward bit 0, tdo presents bit 0, and tdi enters at bit 2W-1.
- R4: EXTEST (5'b00000) drives pin_out from the update latch with pin_oe high. An update strobe copies boundary bits [2W-1:W] into the latch. Update does this in every mode that selects the boundary register.
- R5: CLAMP (5'b00101) keeps driving the pins from the update latch with pin_oe high, and places the bypass register between tdi and tdo.
- R6: HIGHZ (5'b00110) holds pin_oe low and selects the bypass register.
- R7: Signature mode (5'b01001): each run-test strobe sets latch = {latch[W-2:0], ^(latch & TAP_MASK)} ^ pin_in. The latch drives the pins.
- R8: Pseudorandom mode (5'b01010): each run-test strobe sets latch = {latch[W-2:0], ^(latch & TAP_MASK)}. A zero latch is replaced by SEED.
- R9: Toggle mode (5'b01100): each run-test strobe inverts the latch and loads pin_in into boundary bits [W-1:0].
- R10: Count mode (5'b01111): each run-test strobe adds one to the latch, and the count wraps from all ones to zero.
- R11: An even-parity opcode that is not defined (for example 5'b10001) also selects bypass mode. The bypass opcode itself is 5'b11110.
- R12: A run-test strobe in EXTEST has no effect on the pins. When strobes coincide, capture wins over shift, shift over update, and update over run-test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_opcode | input | 5 | Instruction presented by the TAP |
| ir_update | input | 1 | Load ir_opcode into the decoded mode |
| dr_capture | input | 1 | Capture strobe for the selected data register |
| dr_shift | input | 1 | Shift strobe for the selected data register |
| dr_update | input | 1 | Update strobe, boundary register to latch |
| run_test | input | 1 | Pattern step strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out |
| pin_in | input | WIDTH | Values seen at the input pins |
| func_out | input | WIDTH | Output data from the functional core |
| func_oe | input | 1 | Output enable from the functional core |
| pin_out | output | WIDTH | Data driven to the output pins |
| pin_oe | output | 1 | Output enable to the pins |

## Verification
The signature mode is fed a fixed table of eight input words. After each step the outputs are compared against a model of the compression, so an error in tap selection, shift direction or input folding shows up in the step where it first appears. Pseudorandom mode starts from a zero latch, which exposes both the seed substitution and the stepping without input. Count starts one below all ones to reach the wrap. Toggle runs with a different input word on each step, which separates a register that captures inputs from one that only inverts. Odd opcodes and undefined even opcodes are each loaded after a test mode, to show that both give control of the pins back to the core.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [3:0] {
        M_BYPASS,
        M_SAMPLE,
        M_EXTEST,
        M_CLAMP,
        M_HIGHZ,
        M_PSA,
        M_PRPG,
        M_TOGGLE,
        M_COUNT
    } bs_mode_e;

    // Opcodes, all with even parity
    localparam logic [OPC_W-1:0] OPC_EXTEST = 5'b00000;
    localparam logic [OPC_W-1:0] OPC_SAMPLE = 5'b00011;
    localparam logic [OPC_W-1:0] OPC_CLAMP  = 5'b00101;
    localparam logic [OPC_W-1:0] OPC_HIGHZ  = 5'b00110;
    localparam logic [OPC_W-1:0] OPC_PSA    = 5'b01001;
    localparam logic [OPC_W-1:0] OPC_PRPG   = 5'b01010;
    localparam logic [OPC_W-1:0] OPC_TOGGLE = 5'b01100;
    localparam logic [OPC_W-1:0] OPC_COUNT  = 5'b01111;
    localparam logic [OPC_W-1:0] OPC_BYPASS = 5'b11110;

endpackage

// File: rtl/bscan_opcode_decode.sv
module bscan_opcode_decode
    import bscan_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output bs_mode_e         mode
);

    logic parity_odd;

    always_comb begin
        parity_odd = ^opcode;
        mode       = M_BYPASS;
        if (!parity_odd) begin
            unique case (opcode)
                OPC_EXTEST: mode = M_EXTEST;
                OPC_SAMPLE: mode = M_SAMPLE;
                OPC_CLAMP:  mode = M_CLAMP;
                OPC_HIGHZ:  mode = M_HIGHZ;
                OPC_PSA:    mode = M_PSA;
                OPC_PRPG:   mode = M_PRPG;
                OPC_TOGGLE: mode = M_TOGGLE;
                OPC_COUNT:  mode = M_COUNT;
                default:    mode = M_BYPASS;
            endcase
        end
    end

endmodule

// File: rtl/bscan_pattern_step.sv
module bscan_pattern_step
    import bscan_pkg::*;
#(
    parameter int              WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8,
    parameter logic [WIDTH-1:0] SEED     = 8'h01
) (
    input  bs_mode_e         mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] nxt
);

    logic             feedback;
    logic [WIDTH-1:0] lfsr_adv;

    always_comb begin
        feedback = ^(cur & TAP_MASK);
        lfsr_adv = {cur[WIDTH-2:0], feedback};
        unique case (mode)
            M_PSA:    nxt = lfsr_adv ^ pins;
            M_PRPG:   nxt = (cur == '0) ? SEED : lfsr_adv;
            M_TOGGLE: nxt = ~cur;
            M_COUNT:  nxt = cur + WIDTH'(1);
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/bscan_pattern_engine.sv
module bscan_pattern_engine
    import bscan_pkg::*;
#(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8,
    parameter logic [WIDTH-1:0] SEED     = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] ir_opcode,
    input  logic             ir_update,
    input  logic             dr_capture,
    input  logic             dr_shift,
    input  logic             dr_update,
    input  logic             run_test,
    input  logic             tdi,
    output logic             tdo,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] func_out,
    input  logic             func_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_oe
);

    localparam int BSR_W = 2 * WIDTH;

    typedef struct packed {
        bs_mode_e         mode;
        logic [BSR_W-1:0] bsr;
        logic [WIDTH-1:0] latch;
        logic             byp;
    } eng_state_t;

    eng_state_t s_d, s_q;

    bs_mode_e         dec_mode;
    logic [WIDTH-1:0] step_nxt;
    logic             sel_bsr_q;
    logic             test_drive_q;
    logic             pattern_q;
    logic [WIDTH-1:0] bsr_hi_q;
    bs_mode_e         mode_q;

    bscan_opcode_decode i_decode (
        .opcode (ir_opcode),
        .mode   (dec_mode)
    );

    bscan_pattern_step #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAP_MASK),
        .SEED     (SEED)
    ) i_step (
        .mode (s_q.mode),
        .cur  (s_q.latch),
        .pins (pin_in),
        .nxt  (step_nxt)
    );

    always_comb begin
        mode_q       = s_q.mode;
        bsr_hi_q     = s_q.bsr[BSR_W-1:WIDTH];
        sel_bsr_q    = mode_q inside {M_SAMPLE, M_EXTEST, M_PSA, M_PRPG, M_TOGGLE, M_COUNT};
        pattern_q    = mode_q inside {M_PSA, M_PRPG, M_TOGGLE, M_COUNT};
        test_drive_q = !(mode_q inside {M_BYPASS, M_SAMPLE});
    end

    // Pin multiplexer and serial output
    always_comb begin
        pin_out = test_drive_q ? s_q.latch : func_out;
        if (mode_q == M_HIGHZ) begin
            pin_oe = 1'b0;
        end else begin
            pin_oe = test_drive_q ? 1'b1 : func_oe;
        end
        tdo = sel_bsr_q ? s_q.bsr[0] : s_q.byp;
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;
        if (ir_update) begin
            s_d.mode = dec_mode;
        end
        if (dr_capture) begin
            if (sel_bsr_q) begin
                s_d.bsr = {pin_out, pin_in};
            end else begin
                s_d.byp = 1'b0;
            end
        end else if (dr_shift) begin
            if (sel_bsr_q) begin
                s_d.bsr = {tdi, s_q.bsr[BSR_W-1:1]};
            end else begin
                s_d.byp = tdi;
            end
        end else if (dr_update) begin
            if (sel_bsr_q) begin
                s_d.latch = bsr_hi_q;
            end
        end else if (run_test && pattern_q) begin
            s_d.latch = step_nxt;
            if (mode_q == M_TOGGLE) begin
                s_d.bsr[WIDTH-1:0] = pin_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: M_BYPASS, bsr: '0, latch: '0, byp: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/bscan_pattern_engine_chk.sv
module bscan_pattern_engine_chk
    import bscan_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] ir_opcode,
    input logic             ir_update,
    input logic             dr_capture,
    input logic             dr_shift,
    input logic             dr_update,
    input logic             run_test,
    input logic [WIDTH-1:0] func_out,
    input logic             func_oe,
    input logic [WIDTH-1:0] pin_out,
    input logic             pin_oe,
    input bs_mode_e         mode_q,
    input logic [WIDTH-1:0] bsr_hi_q
);

    logic only_run;
    logic only_update;

    always_comb begin
        only_run    = run_test && !dr_capture && !dr_shift && !dr_update && !ir_update;
        only_update = dr_update && !dr_capture && !dr_shift && !ir_update;
    end

    // R1 / R2 / R11: bypass keeps the core in control of the pins
    a_r1_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_BYPASS) |-> (pin_out == func_out) && (pin_oe == func_oe));

    a_r2_odd_opcode_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_update && ^ir_opcode) |=> (mode_q == M_BYPASS));

    a_r4_update_drives_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_EXTEST && only_update) |=> (pin_out == $past(bsr_hi_q)) && pin_oe);

    a_r6_highz_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_HIGHZ) |-> !pin_oe);

    a_r9_toggle_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_TOGGLE && only_run) |=> (pin_out == ~$past(pin_out)));

    a_r10_count_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_COUNT && only_run) |=> (pin_out == $past(pin_out) + WIDTH'(1)));

    a_r12_run_idle_in_extest: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_EXTEST && only_run) |=> $stable(pin_out));

endmodule

bind bscan_pattern_engine bscan_pattern_engine_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ir_opcode  (ir_opcode),
    .ir_update  (ir_update),
    .dr_capture (dr_capture),
    .dr_shift   (dr_shift),
    .dr_update  (dr_update),
    .run_test   (run_test),
    .func_out   (func_out),
    .func_oe    (func_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .mode_q     (mode_q),
    .bsr_hi_q   (bsr_hi_q)
);

// File: tb/test_bscan_pattern_engine.sv
`timescale 1ns/1ps
module test_bscan_pattern_engine;

    localparam int W = 8;
    localparam logic [W-1:0] TAPS = 8'hB8;
    localparam logic [W-1:0] SEED = 8'h01;

    localparam logic [4:0] C_EXTEST = 5'b00000;
    localparam logic [4:0] C_SAMPLE = 5'b00011;
    localparam logic [4:0] C_CLAMP  = 5'b00101;
    localparam logic [4:0] C_HIGHZ  = 5'b00110;
    localparam logic [4:0] C_PSA    = 5'b01001;
    localparam logic [4:0] C_PRPG   = 5'b01010;
    localparam logic [4:0] C_TOGGLE = 5'b01100;
    localparam logic [4:0] C_COUNT  = 5'b01111;
    localparam logic [4:0] C_ODD    = 5'b00001;
    localparam logic [4:0] C_UNDEF  = 5'b10001;

    localparam int NVEC = 8;
    localparam logic [W-1:0] PSA_VEC [NVEC] = '{8'h00, 8'hFF, 8'h13, 8'hA7, 8'h80, 8'h01, 8'h5C, 8'h3E};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   ir_opcode = '0;
    logic         ir_update = 1'b0;
    logic         dr_capture = 1'b0;
    logic         dr_shift = 1'b0;
    logic         dr_update = 1'b0;
    logic         run_test = 1'b0;
    logic         tdi = 1'b0;
    logic         tdo;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] func_out = 8'h96;
    logic         func_oe = 1'b1;
    logic [W-1:0] pin_out;
    logic         pin_oe;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    bscan_pattern_engine #(.WIDTH(W), .TAP_MASK(TAPS), .SEED(SEED)) i_bscan_pattern_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .ir_opcode  (ir_opcode),
        .ir_update  (ir_update),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .dr_update  (dr_update),
        .run_test   (run_test),
        .tdi        (tdi),
        .tdo        (tdo),
        .pin_in     (pin_in),
        .func_out   (func_out),
        .func_oe    (func_oe),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    function automatic logic [W-1:0] lfsr_ref(input logic [W-1:0] v);
        return {v[W-2:0], ^(v & TAPS)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_ir(input logic [4:0] code);
        ir_opcode = code;
        ir_update = 1'b1;
        tick();
        ir_update = 1'b0;
    endtask

    task automatic do_capture();
        dr_capture = 1'b1; tick(); dr_capture = 1'b0;
    endtask

    task automatic do_update();
        dr_update = 1'b1; tick(); dr_update = 1'b0;
    endtask

    task automatic do_run();
        run_test = 1'b1; tick(); run_test = 1'b0;
    endtask

    task automatic shift_dr(input logic [15:0] vin, input int n, output logic [15:0] vout);
        vout = '0;
        dr_shift = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi = vin[i];
            vout[i] = tdo;
            tick();
        end
        dr_shift = 1'b0;
    endtask

    task automatic preload_latch(input logic [W-1:0] v);
        logic [15:0] dummy;
        load_ir(C_EXTEST);
        shift_dr({v, 8'h00}, 16, dummy);
        do_update();
    endtask

    task automatic run_tests();
        logic [15:0] so;
        logic [W-1:0] model;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1: reset state hands pins to the core
        check("R1 pin_out after reset", {8'h00, pin_out}, {8'h00, func_out});
        check("R1 pin_oe after reset", {15'h0, pin_oe}, {15'h0, func_oe});

        // R3: sample is non-invasive, capture loads pins and core data
        pin_in = 8'hA5; func_out = 8'h3C;
        load_ir(C_SAMPLE);
        check("R3 sample leaves pins", {7'h0, pin_oe, pin_out}, {7'h0, func_oe, func_out});
        do_capture();
        shift_dr(16'h0000, 16, so);
        check("R3 captured boundary word", so, 16'h3CA5);

        // R4: extest drives latched data, overriding a disabled core
        func_oe = 1'b0;
        load_ir(C_EXTEST);
        shift_dr(16'h5A00, 16, so);
        do_update();
        check("R4 extest pin_out", {8'h00, pin_out}, 16'h005A);
        check("R4 extest pin_oe", {15'h0, pin_oe}, 16'h0001);

        // R12: run-test ignored in extest
        pin_in = 8'hFF;
        do_run();
        check("R12 extest run ignored", {8'h00, pin_out}, 16'h005A);

        // R5: clamp holds latch on pins, bypass between tdi and tdo
        load_ir(C_CLAMP);
        check("R5 clamp pins", {7'h0, pin_oe, pin_out}, {7'h0, 1'b1, 8'h5A});
        shift_dr(16'h0001, 2, so);
        check("R5 clamp one-bit path", {15'h0, so[1]}, 16'h0001);

        // R6: highz disables outputs, bypass selected
        load_ir(C_HIGHZ);
        check("R6 highz oe", {15'h0, pin_oe}, 16'h0000);
        shift_dr(16'h0001, 2, so);
        check("R6 highz one-bit path", {15'h0, so[1]}, 16'h0001);

        // R7: signature compression over a table of input words
        load_ir(C_PSA);
        model = 8'h5A;
        for (int i = 0; i < NVEC; i++) begin
            pin_in = PSA_VEC[i];
            do_run();
            model = lfsr_ref(model) ^ PSA_VEC[i];
            check("R7 signature step", {8'h00, pin_out}, {8'h00, model});
        end

        // R8: pseudorandom from zero latch picks up the seed
        preload_latch(8'h00);
        load_ir(C_PRPG);
        do_run();
        check("R8 seed from zero", {8'h00, pin_out}, {8'h00, SEED});
        model = SEED;
        for (int i = 0; i < 6; i++) begin
            do_run();
            model = lfsr_ref(model);
            check("R8 prpg step", {8'h00, pin_out}, {8'h00, model});
        end

        // R9: toggle inverts outputs and samples inputs each step
        preload_latch(8'h0F);
        load_ir(C_TOGGLE);
        pin_in = 8'hC3;
        do_run();
        check("R9 toggle first", {8'h00, pin_out}, 16'h00F0);
        pin_in = 8'h3C;
        do_run();
        check("R9 toggle second", {8'h00, pin_out}, 16'h000F);
        pin_in = 8'h00;
        shift_dr(16'h0000, 16, so);
        check("R9 toggle sampled inputs", so, 16'h0F3C);

        // R10: count wraps from all ones
        preload_latch(8'hFE);
        load_ir(C_COUNT);
        do_run();
        check("R10 count to max", {8'h00, pin_out}, 16'h00FF);
        do_run();
        check("R10 count wrap", {8'h00, pin_out}, 16'h0000);

        // R2: odd opcode returns pins to core, one-bit path
        func_out = 8'h69; func_oe = 1'b1;
        load_ir(C_ODD);
        check("R2 odd opcode pins", {7'h0, pin_oe, pin_out}, {7'h0, 1'b1, 8'h69});
        shift_dr(16'h0001, 2, so);
        check("R2 odd opcode one-bit path", {15'h0, so[1]}, 16'h0001);

        // R11: undefined even opcode behaves as bypass
        load_ir(C_COUNT);
        func_oe = 1'b0;
        load_ir(C_UNDEF);
        check("R11 undefined opcode pins", {7'h0, pin_oe, pin_out}, {7'h0, 1'b0, 8'h69});

        // R12: capture wins over a coincident shift
        load_ir(C_SAMPLE);
        pin_in = 8'h81; func_out = 8'h24;
        dr_capture = 1'b1; dr_shift = 1'b1; tdi = 1'b1;
        tick();
        dr_capture = 1'b0; dr_shift = 1'b0;
        shift_dr(16'h0000, 16, so);
        check("R12 capture priority", so, 16'h2481);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule